// File: doc/BRIEF.md
# SPI Flash Register Transfer Engine

This peripheral lets a processor drive a serial flash device one register access at a time. Software pulls one of two active-low chip-select bits low in the control word and picks a byte count of one to four. Each write to the data register then shifts that many bytes out on a single-lane SPI master port, starting with the top byte of the word. Each read of the data register returns the word most recently shifted in. The select line stays low across any number of data accesses, so a complete flash command (opcode, address, dummy byte, payload) is assembled from several accesses. It ends when software sets the select bits high again.

The bus is a plain 32-bit register port with a word index. A read returns its data on the cycle after the strobe. A ready bit in the control word reports whether the shifter is idle, and software polls it around every data access. While a select is held, a data read also starts the next receive, so a run of reads streams bytes out of the flash. The serial clock follows SPI mode 0, and its rate is set by a divider field in the configuration register.

Top module: `sfx_engine`

## Requirements
- R1: After reset both select pins are high, SCLK is low and the control word (index 2) reads 0xC800_0000: both select bits 1, length 0, ready (bit 27) 1.
- R2: Control bit 31 drives select pin 0 and control bit 30 drives select pin 1, both active low. The pins keep their value through any number of data accesses until the control word is written again.
- R3: A write to the data register (index 3) shifts out len+1 bytes, where len is control bits 29:28. The bytes come from bit 31 downward, each byte MSB first.
- R4: Received bits fill the data word from bit 31 downward, first byte in the top byte. Bits below the received bytes read 0.
- R5: A data read returns the last received word. If either select bit is 0, the read also starts a receive of len+1 bytes with MOSI held low. If both select bits are 1, no transfer starts.
- R6: Ready reads 0 from the cycle after a transfer starts until 2×(div+1)×8×(len+1) clock edges have passed, and 1 after that.
- R7: SCLK idles low. Each SCLK half period lasts div+1 bus clocks, where div is configuration bits 31:29. MOSI never changes on a rising SCLK edge and MISO is sampled on the rising edge.
- R8: A control write that changes only the length field starts no transfer and leaves the select pins unchanged.
- R9: Any register write made while ready is 0 is discarded.
- R10: The configuration register (index 0) keeps bits 31:23 and reads 0 below them. Index 1 and index 4 hold full 32-bit words. Of all these fields, only the divider affects a transfer.
- R11: Control bits 26:25 and bit 24 read back as written, and control bits 23:0 read 0. Unmapped indices 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and engine clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_csn | output | 2 | Active-low device selects, index = device |

## Verification
The bound checker watches four properties on every cycle: SCLK is low whenever the shifter is idle, the select pins do not move during a transfer, MOSI holds still at each rising SCLK edge, and every SCLK half period lasts exactly div+1 clocks. The bench's reference model follows the bus strobes and predicts the select pins and the idle clock each cycle. Everything that depends on data has to come from the scenarios: bytes serialised from the top of the word, left-justified receive words, the streaming receive started by a read, the exact ready window, and writes discarded while busy.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

  // Register word indices on the bus (byte offset / 4).
  localparam int unsigned IX_CFG   = 0;
  localparam int unsigned IX_MCFG  = 1;
  localparam int unsigned IX_CTL   = 2;
  localparam int unsigned IX_DATA  = 3;
  localparam int unsigned IX_DATA2 = 4;

  // Width of the chip-select setup field kept in the configuration word.
  localparam int unsigned SETUP_W  = 4;
  // Width of the I/O lane-count field in the control word.
  localparam int unsigned IOW_W    = 2;

endpackage

// File: rtl/sfx_clkgen.sv
module sfx_clkgen #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  // Counts div+1 clocks per SCLK half period; held at zero while idle so
  // the first half period after a start is full length.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == div) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == div);

endmodule

// File: rtl/sfx_shifter.sv
module sfx_shifter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);

  localparam int unsigned BIT_W = $clog2(DATA_W);

  logic              busy_q;
  logic              sclk_q;
  logic              mosi_q;
  logic [DATA_W-2:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BIT_W-1:0]  last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      last_q <= '0;
    end else if (!busy_q) begin
      sclk_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        mosi_q <= tx_word[DATA_W-1];
        tx_q   <= tx_word[DATA_W-2:0];
        rx_q   <= '0;
        bit_q  <= '0;
        last_q <= BIT_W'({len_m1, 3'b111});
      end
    end else if (tick) begin
      if (!sclk_q) begin
        // Rising edge: capture the incoming bit, left-justified.
        sclk_q <= 1'b1;
        rx_q[BIT_W'(DATA_W-1) - bit_q] <= miso;
      end else begin
        // Falling edge: present the next bit or finish.
        sclk_q <= 1'b0;
        if (bit_q == last_q) begin
          busy_q <= 1'b0;
          mosi_q <= 1'b0;
        end else begin
          bit_q  <= bit_q + 1'b1;
          mosi_q <= tx_q[DATA_W-2];
          tx_q   <= {tx_q[DATA_W-3:0], 1'b0};
        end
      end
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign rx_word = rx_q;

endmodule

// File: rtl/sfx_regs.sv
module sfx_regs
  import sfx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DIV_W  = 3,
  parameter int unsigned LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] rx_word,
  output logic              start,
  output logic [DATA_W-1:0] tx_word,
  output logic [1:0]        sel_n,
  output logic [DIV_W-1:0]  div,
  output logic [LEN_W-1:0]  len_m1
);

  localparam int unsigned CFG_W   = DIV_W + 2 + SETUP_W;
  localparam int unsigned CFG_PAD = DATA_W - CFG_W;
  localparam int unsigned LEN_HI  = DATA_W - 3;
  localparam int unsigned IOW_HI  = DATA_W - 4 - LEN_W;
  localparam int unsigned TSEL_B  = DATA_W - 4 - LEN_W - IOW_W;
  localparam int unsigned CTL_PAD = TSEL_B;

  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(IX_CFG);
  localparam logic [ADDR_W-1:0] A_MCFG  = ADDR_W'(IX_MCFG);
  localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(IX_CTL);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(IX_DATA);
  localparam logic [ADDR_W-1:0] A_DATA2 = ADDR_W'(IX_DATA2);

  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] mcfg_q;
  logic [DATA_W-1:0] data2_q;
  logic              dev0_n_q;
  logic              dev1_n_q;
  logic [LEN_W-1:0]  len_q;
  logic [IOW_W-1:0]  iow_q;
  logic              tsel_q;
  logic              wr_ok;
  logic              any_sel;

  assign wr_ok   = bus_wr && !busy;
  assign any_sel = !(dev0_n_q && dev1_n_q);

  // Register writes; every write is dropped while the shifter runs.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      mcfg_q   <= '0;
      data2_q  <= '0;
      dev0_n_q <= 1'b1;
      dev1_n_q <= 1'b1;
      len_q    <= '0;
      iow_q    <= '0;
      tsel_q   <= 1'b0;
    end else if (wr_ok) begin
      case (bus_addr)
        A_CFG:   cfg_q   <= bus_wdata[DATA_W-1 -: CFG_W];
        A_MCFG:  mcfg_q  <= bus_wdata;
        A_DATA2: data2_q <= bus_wdata;
        A_CTL: begin
          dev0_n_q <= bus_wdata[DATA_W-1];
          dev1_n_q <= bus_wdata[DATA_W-2];
          len_q    <= bus_wdata[LEN_HI -: LEN_W];
          iow_q    <= bus_wdata[IOW_HI -: IOW_W];
          tsel_q   <= bus_wdata[TSEL_B];
        end
        default: ;
      endcase
    end
  end

  // Transfer launch: a data write sends the word, a data read with a
  // select held clocks in a fresh word while sending zeros.
  always_comb begin
    start   = 1'b0;
    tx_word = '0;
    if (!busy && bus_addr == A_DATA) begin
      if (bus_wr) begin
        start   = 1'b1;
        tx_word = bus_wdata;
      end else if (bus_rd && any_sel) begin
        start   = 1'b1;
      end
    end
  end

  // Registered read data.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CFG:   bus_rdata <= {cfg_q, {CFG_PAD{1'b0}}};
        A_MCFG:  bus_rdata <= mcfg_q;
        A_CTL:   bus_rdata <= {dev0_n_q, dev1_n_q, len_q, !busy, iow_q,
                               tsel_q, {CTL_PAD{1'b0}}};
        A_DATA:  bus_rdata <= rx_word;
        A_DATA2: bus_rdata <= data2_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign sel_n  = {dev1_n_q, dev0_n_q};
  assign div    = cfg_q[CFG_W-1 -: DIV_W];
  assign len_m1 = len_q;

endmodule

// File: rtl/sfx_engine.sv
module sfx_engine #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DIV_W  = 3,
  parameter int unsigned LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [1:0]        spi_csn
);

  logic              shift_busy;
  logic              shift_start;
  logic              half_tick;
  logic [DATA_W-1:0] tx_word;
  logic [DATA_W-1:0] rx_word;
  logic [DIV_W-1:0]  cfg_div;
  logic [LEN_W-1:0]  len_m1;

  sfx_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DIV_W  (DIV_W),
    .LEN_W  (LEN_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (shift_busy),
    .rx_word   (rx_word),
    .start     (shift_start),
    .tx_word   (tx_word),
    .sel_n     (spi_csn),
    .div       (cfg_div),
    .len_m1    (len_m1)
  );

  sfx_clkgen #(
    .DIV_W (DIV_W)
  ) u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .run  (shift_busy),
    .div  (cfg_div),
    .tick (half_tick)
  );

  sfx_shifter #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
  ) u_shifter (
    .clk     (clk),
    .rst     (rst),
    .start   (shift_start),
    .tx_word (tx_word),
    .len_m1  (len_m1),
    .tick    (half_tick),
    .miso    (spi_miso),
    .busy    (shift_busy),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .rx_word (rx_word)
  );

endmodule

// File: rtl/sfx_engine_chk.sv
module sfx_engine_chk #(
  parameter int unsigned DIV_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             spi_sclk,
  input logic             spi_mosi,
  input logic [1:0]       spi_csn,
  input logic [DIV_W-1:0] div
);

  logic             sclk_q;
  logic [DIV_W:0]   lvl_cnt;

  // Clocks spent at the current SCLK level since the last toggle or start.
  always_ff @(posedge clk) begin
    sclk_q <= spi_sclk;
    if (rst || !busy) begin
      lvl_cnt <= '0;
    end else if (spi_sclk != sclk_q) begin
      lvl_cnt <= {{DIV_W{1'b0}}, 1'b1};
    end else begin
      lvl_cnt <= lvl_cnt + 1'b1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !spi_sclk); // R7

  AST_CSN_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(spi_csn)); // R9

  AST_MOSI_HOLD_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sclk) |-> $stable(spi_mosi)); // R7

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (busy && (spi_sclk != sclk_q)) |-> (lvl_cnt == ({1'b0, div} + 1'b1))); // R7

endmodule

bind sfx_engine sfx_engine_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (shift_busy),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi),
  .spi_csn  (spi_csn),
  .div      (cfg_div)
);

// File: tb/sfx_engine_bench.sv
`timescale 1ns/1ps
module sfx_engine_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [1:0]  spi_csn;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  sfx_engine u_sfx_engine (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_csn(spi_csn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Flash-side model: MISO shifts on falling SCLK, MOSI captured on rising.
  logic [31:0] slave_word = '0;
  logic        slave_ld = 1'b0;
  logic [31:0] slave_out;
  logic        cap_clr = 1'b0;
  logic [31:0] cap;
  int          cap_cnt;
  longint      t_last, t_per;

  assign spi_miso = slave_out[31];

  always @(negedge spi_sclk or posedge slave_ld)
    if (slave_ld) slave_out <= slave_word;
    else          slave_out <= slave_out << 1;

  always @(posedge spi_sclk or posedge cap_clr)
    if (cap_clr) begin
      cap <= '0; cap_cnt <= 0; t_per <= 0;
    end else begin
      cap <= {cap[30:0], spi_mosi};
      cap_cnt <= cap_cnt + 1;
      if (cap_cnt > 0) t_per <= $time - t_last;
      t_last <= $time;
    end

  task automatic slave_load(input logic [31:0] w);
    slave_word = w; slave_ld = 1'b1; #1; slave_ld = 1'b0;
  endtask

  task automatic cap_clear();
    cap_clr = 1'b1; #1; cap_clr = 1'b0;
  endtask

  // Behavioural reference: tracks selects and remaining busy clocks.
  int          m_rem;
  logic [1:0]  m_csn;
  logic [2:0]  m_div;
  logic [1:0]  m_len;

  function automatic int xfer_len(input logic [2:0] d, input logic [1:0] l);
    return 2 * (int'(d) + 1) * 8 * (int'(l) + 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rem <= 0; m_csn <= 2'b11; m_div <= '0; m_len <= '0;
    end else if (m_rem == 0) begin
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_div <= bus_wdata[31:29];
          3'd2: begin m_csn <= {bus_wdata[30], bus_wdata[31]}; m_len <= bus_wdata[29:28]; end
          3'd3: m_rem <= xfer_len(m_div, m_len);
          default: ;
        endcase
      end else if (bus_rd && bus_addr == 3'd3 && m_csn != 2'b11) begin
        m_rem <= xfer_len(m_div, m_len);
      end
    end else begin
      m_rem <= m_rem - 1;
    end
  end

  always @(negedge clk)
    if (!rst) begin
      chk("R2 per-cycle select pins", {30'd0, spi_csn}, {30'd0, m_csn});
      if (m_rem == 0) chk("R7 per-cycle idle clock", {31'd0, spi_sclk}, 32'd0);
    end

  // Bus tasks: called at a negedge, return at the next negedge.
  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_ready(output int busy_reads);
    logic [31:0] r;
    busy_reads = 0;
    for (int i = 0; i < 5000; i++) begin
      bus_read(3'd2, r);
      if (r[27]) break;
      busy_reads++;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R6 watchdog actual=expired expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int n;
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 select pins", {30'd0, spi_csn}, 32'd3);
    chk("R1 sclk low", {31'd0, spi_sclk}, 32'd0);
    bus_read(3'd2, r);  chk("R1 control word", r, 32'hC800_0000);

    // R10 storage registers
    bus_write(3'd0, 32'hFFFF_FFFF); bus_read(3'd0, r); chk("R10 cfg keeps 31:23", r, 32'hFF80_0000);
    bus_write(3'd1, 32'h1234_5678); bus_read(3'd1, r); chk("R10 index 1", r, 32'h1234_5678);
    bus_write(3'd4, 32'hCAFE_F00D); bus_read(3'd4, r); chk("R10 index 4", r, 32'hCAFE_F00D);
    bus_write(3'd0, 32'h2000_0000); bus_read(3'd0, r); chk("R10 divider 1", r, 32'h2000_0000);
    bus_read(3'd6, r); chk("R11 unmapped index", r, 32'd0);

    // R2 select device 0, 4-byte length
    bus_write(3'd2, 32'h7000_0000);
    chk("R2 device 0 selected", {30'd0, spi_csn}, 32'd2);
    bus_read(3'd2, r); chk("R11 control readback", r, 32'h7800_0000);

    // R3 / R6 / R7: 4-byte write, div=1
    slave_load(32'hA5C3_0F81); cap_clear();
    bus_write(3'd3, 32'h9F12_3456);
    wait_ready(n);
    chk("R6 busy window 4 bytes div 1", n, 32'd128);
    chk("R3 mosi word", cap, 32'h9F12_3456);
    chk("R3 bit count", cap_cnt, 32'd32);
    chk("R7 sclk period div 1", 32'(t_per), 32'd32);
    chk("R2 select held after data", {30'd0, spi_csn}, 32'd2);

    // R4 / R5: read returns word and streams the next one
    cap_clear(); slave_load(32'h1122_3344);
    bus_read(3'd3, r); chk("R4 received word", r, 32'hA5C3_0F81);
    wait_ready(n); chk("R5 read starts receive", n, 32'd128);
    chk("R5 mosi low during receive", cap, 32'd0);
    chk("R5 receive bit count", cap_cnt, 32'd32);
    bus_read(3'd3, r); chk("R5 streamed word", r, 32'h1122_3344);
    wait_ready(n);

    // R8 length-only change
    cap_clear();
    bus_write(3'd2, 32'h4000_0000);
    chk("R8 pins unchanged", {30'd0, spi_csn}, 32'd2);
    repeat (20) @(negedge clk);
    chk("R8 no clock", cap_cnt, 32'd0);
    bus_read(3'd2, r); chk("R8 length updated ready", r, 32'h4800_0000);

    // R3 1-byte write, R4 left justification
    slave_load(32'h5A11_2233); cap_clear();
    bus_write(3'd3, 32'hE7C0_FFEE);
    wait_ready(n); chk("R6 busy window 1 byte", n, 32'd32);
    chk("R3 single byte", cap, 32'h0000_00E7);
    chk("R3 single byte count", cap_cnt, 32'd8);
    bus_read(3'd3, r); chk("R4 low bits zero", r, 32'h5A00_0000);
    wait_ready(n);

    // R9 writes while busy are discarded (2-byte transfer)
    bus_write(3'd2, 32'h5000_0000);
    slave_load(32'hBEEF_1234); cap_clear();
    bus_write(3'd3, 32'h0F0F_AAAA);
    bus_write(3'd2, 32'hC000_0000);
    bus_write(3'd0, 32'hE000_0000);
    bus_write(3'd3, 32'hFFFF_FFFF);
    chk("R9 pins kept", {30'd0, spi_csn}, 32'd2);
    wait_ready(n);
    chk("R9 two bytes only", cap, 32'h0000_0F0F);
    chk("R3 two byte count", cap_cnt, 32'd16);
    bus_read(3'd2, r); chk("R9 control unchanged", r, 32'h5800_0000);
    bus_read(3'd0, r); chk("R9 cfg unchanged", r, 32'h2000_0000);

    // R5 deselected read: no transfer
    bus_write(3'd2, 32'hC000_0000);
    chk("R2 both released", {30'd0, spi_csn}, 32'd3);
    cap_clear();
    bus_read(3'd3, r); chk("R4 two byte receive", r, 32'hBEEF_0000);
    bus_read(3'd2, r); chk("R5 no transfer when deselected", r, 32'hC800_0000);
    repeat (10) @(negedge clk);
    chk("R5 no clock when deselected", cap_cnt, 32'd0);

    // R11 / R2 device 1 and field readback
    bus_write(3'd2, 32'h8100_0000);
    chk("R2 device 1 selected", {30'd0, spi_csn}, 32'd1);
    bus_read(3'd2, r); chk("R11 target bit", r, 32'h8900_0000);
    bus_write(3'd2, 32'hC600_0000);
    bus_read(3'd2, r); chk("R11 width bits", r, 32'hCE00_0000);

    // R7 divider 0 on device 1
    bus_write(3'd0, 32'h0000_0000);
    bus_write(3'd2, 32'h8000_0000);
    slave_load(32'hC300_0000); cap_clear();
    bus_write(3'd3, 32'h3C00_0000);
    wait_ready(n); chk("R7 busy window div 0", n, 32'd16);
    chk("R7 sclk period div 0", 32'(t_per), 32'd16);
    chk("R3 byte on device 1", cap, 32'h0000_003C);
    bus_read(3'd3, r); chk("R4 device 1 receive", r, 32'hC300_0000);
    wait_ready(n);
    bus_write(3'd2, 32'hC000_0000);
    repeat (4) @(negedge clk);

    finish_run();
  end

endmodule